// File: doc/BRIEF.md
# Periodic Thermal Sampler with Debounced Alarm and Shutdown

This block drives a temperature-sensing ADC on its own and watches every result. While it is enabled, an idle-cycle timer issues a one-cycle start pulse to the converter. The matching done pulse returns a 12-bit code, which the block stores and tests against two programmable limits. A hotter die gives a lower code, so a sample counts as too hot when its code is less than or equal to the limit.

Each limit has its own run-length counter. The alarm interrupt qualifies after a run of consecutive hot samples, and so does the hard shutdown output. A single cool sample resets the run for that limit. While the most recent sample is past the alarm limit, the block samples on a short interval, and it returns to the long interval once a sample comes back cool. Software uses a small word-addressed register port to enable the block, set the limits, mask the interrupt, route the shutdown output, read the latest code and clear the pending alarm.

Top module: `thermal_poll_ctrl`

Register map (word address on `bus_addr`): 0 control, 1 interrupt enable, 2 pending, 3 latest code (read only), 4 alarm limit, 5 shutdown limit. Both limits use bits 11:0.

## Requirements
- R1: When the last accepted sample was cool, `adc_start` rises exactly SLOW_TICKS (default 1000) clock edges after the edge that captured the previous `adc_done`, or after the edge of the write that enabled the block. It lasts one cycle.
- R2: When the last accepted sample had a code less than or equal to the alarm limit, that gap is FAST_TICKS (default 100) edges instead. The next cool sample restores the SLOW_TICKS gap.
- R3: The alarm pending flag (pending register bit 1) sets on the QUAL_N-th (default 10) consecutive sample at or below the alarm limit. Any sample above the limit sets the run back to zero.
- R4: `irq` is high exactly when alarm pending is set and interrupt-enable bit 1 is set. Clearing that enable bit drops `irq` but keeps the pending flag.
- R5: A write to the pending register with bit 1 set clears the alarm pending flag. If a qualifying sample arrives in the same cycle, the flag stays set.
- R6: The shutdown pending flag (pending register bit 5) sets on the QUAL_N-th consecutive sample at or below the shutdown limit. This run is counted apart from the alarm run.
- R7: `shut_out` asserts on that same sample when interrupt-enable bit 5 is set. Once high, it stays high until reset, whatever later samples show.
- R8: Polling runs only while control bit 0 (automatic enable) and control bit 5 (sensor source enable) are both 1. If either is 0, no `adc_start` is issued.
- R9: Control register bit 16 reads 1 from the start pulse until the done pulse is accepted, and 0 otherwise.
- R10: The latest-code register returns the code of the most recently accepted done pulse.
- R11: A limit written while polling applies from the next comparison. Writing a limit does not clear either run counter.
- R12: After reset, `adc_start`, `irq` and `shut_out` are 0, and the control, pending and latest-code registers read 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_we | input | 1 | Register write strobe |
| bus_addr | input | 3 | Register word address |
| bus_wdata | input | 32 | Register write data |
| bus_rdata | output | 32 | Register read data (combinational on `bus_addr`) |
| adc_start | output | 1 | One-cycle conversion start |
| adc_done | input | 1 | Conversion complete, qualifies `adc_code` |
| adc_code | input | 12 | Conversion result |
| irq | output | 1 | Alarm interrupt |
| shut_out | output | 1 | Latched hard shutdown request |

## Verification
The hardest state to reach from the ports is a run counter that is partway through a qualifying run and then sees a limit rewrite or a single cool sample. Each run needs many full polling intervals, and every interval depends on the previous result. The bench acts as the converter. It answers every start pulse with a code taken from a vector walk that counts up, breaks the run and restarts it. It checks each start gap in edges against the fast or slow interval implied by the previous code. A directed phase then rewrites the shutdown limit halfway through a hot run and confirms that qualification still lands on the QUAL_N-th sample.

// File: rtl/thermal_poll_ctrl.sv
module thermal_poll_ctrl #(
  parameter int CODE_W     = 12,
  parameter int SLOW_TICKS = 1000,
  parameter int FAST_TICKS = 100,
  parameter int QUAL_N     = 10
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bus_we,
  input  logic [2:0]        bus_addr,
  input  logic [31:0]       bus_wdata,
  output logic [31:0]       bus_rdata,
  output logic              adc_start,
  input  logic              adc_done,
  input  logic [CODE_W-1:0] adc_code,
  output logic              irq,
  output logic              shut_out
);
  localparam int TW = $clog2(SLOW_TICKS + 1);
  localparam int QW = $clog2(QUAL_N + 1);
  localparam logic [TW-1:0] SLOW_LAST = TW'(SLOW_TICKS - 1);
  localparam logic [TW-1:0] FAST_LAST = TW'(FAST_TICKS - 1);
  localparam logic [QW-1:0] Q_MAX  = QW'(QUAL_N);
  localparam logic [QW-1:0] Q_LAST = QW'(QUAL_N - 1);

  logic              auto_en, src_en, ien_alarm, ien_shut;
  logic              pend_a, pend_s, shut_q, start_q, busy, hot_q;
  logic [CODE_W-1:0] alarm_th, shut_th, data_q;
  logic [TW-1:0]     tick;
  logic [QW-1:0]     alarm_cnt, shut_cnt;

  wire run    = auto_en & src_en;
  wire accept = run & busy & adc_done;
  wire hot    = adc_code <= alarm_th;
  wire deep   = adc_code <= shut_th;
  wire [TW-1:0] last_tick = hot_q ? FAST_LAST : SLOW_LAST;
  wire wr_ctrl = bus_we && bus_addr == 3'd0;
  wire wr_ien  = bus_we && bus_addr == 3'd1;
  wire wr_pend = bus_we && bus_addr == 3'd2;
  wire wr_ath  = bus_we && bus_addr == 3'd4;
  wire wr_sth  = bus_we && bus_addr == 3'd5;

  logic unused_wdata;
  assign unused_wdata = ^bus_wdata[31:CODE_W];

  assign adc_start = start_q;
  assign irq       = pend_a & ien_alarm;
  assign shut_out  = shut_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      auto_en <= 1'b0; src_en <= 1'b0; ien_alarm <= 1'b0; ien_shut <= 1'b0;
      alarm_th <= '0; shut_th <= '0;
    end else begin
      if (wr_ctrl) begin auto_en <= bus_wdata[0]; src_en <= bus_wdata[5]; end
      if (wr_ien)  begin ien_alarm <= bus_wdata[1]; ien_shut <= bus_wdata[5]; end
      if (wr_ath)  alarm_th <= bus_wdata[CODE_W-1:0];
      if (wr_sth)  shut_th  <= bus_wdata[CODE_W-1:0];
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      tick <= '0; start_q <= 1'b0; busy <= 1'b0;
    end else begin
      start_q <= 1'b0;
      if (!run) begin
        tick <= '0;
        busy <= 1'b0;
      end else if (!busy) begin
        if (tick == last_tick) begin
          tick    <= '0;
          start_q <= 1'b1;
          busy    <= 1'b1;
        end else begin
          tick <= tick + 1'b1;
        end
      end else if (adc_done) begin
        busy <= 1'b0;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      data_q <= '0; hot_q <= 1'b0; alarm_cnt <= '0; shut_cnt <= '0;
      pend_a <= 1'b0; pend_s <= 1'b0; shut_q <= 1'b0;
    end else begin
      if (wr_pend && bus_wdata[1]) pend_a <= 1'b0;
      if (accept) begin
        data_q <= adc_code;
        hot_q  <= hot;
        if (hot) begin
          if (alarm_cnt != Q_MAX) alarm_cnt <= alarm_cnt + 1'b1;
          if (alarm_cnt >= Q_LAST) pend_a <= 1'b1;
        end else begin
          alarm_cnt <= '0;
        end
        if (deep) begin
          if (shut_cnt != Q_MAX) shut_cnt <= shut_cnt + 1'b1;
          if (shut_cnt >= Q_LAST) begin
            pend_s <= 1'b1;
            if (ien_shut) shut_q <= 1'b1;
          end
        end else begin
          shut_cnt <= '0;
        end
      end
    end
  end

  always_comb begin
    bus_rdata = '0;
    case (bus_addr)
      3'd0: begin bus_rdata[0] = auto_en; bus_rdata[5] = src_en; bus_rdata[16] = busy; end
      3'd1: begin bus_rdata[1] = ien_alarm; bus_rdata[5] = ien_shut; end
      3'd2: begin bus_rdata[1] = pend_a; bus_rdata[5] = pend_s; end
      3'd3: bus_rdata[CODE_W-1:0] = data_q;
      3'd4: bus_rdata[CODE_W-1:0] = alarm_th;
      3'd5: bus_rdata[CODE_W-1:0] = shut_th;
      default: bus_rdata = '0;
    endcase
  end
endmodule

// File: rtl/thermal_poll_ctrl_chk.sv
module thermal_poll_ctrl_chk #(
  parameter int QUAL_N = 10,
  parameter int QW     = 4
) (
  input logic          clk,
  input logic          rst_n,
  input logic          adc_start,
  input logic          adc_done,
  input logic          busy,
  input logic          pend_a,
  input logic          shut_out,
  input logic [QW-1:0] alarm_cnt
);
  assert_start_pulse_R1: assert property (@(posedge clk) disable iff (!rst_n)
    adc_start |=> !adc_start);
  assert_no_start_in_flight_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && $past(busy)) |-> !adc_start);
  assert_alarm_from_sample_R3: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(pend_a) |-> $past(adc_done));
  assert_run_bounded_R3: assert property (@(posedge clk) disable iff (!rst_n)
    alarm_cnt <= QW'(QUAL_N));
  assert_shut_from_sample_R6: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(shut_out) |-> $past(adc_done));
  assert_shut_latched_R7: assert property (@(posedge clk) disable iff (!rst_n)
    shut_out |=> shut_out);
endmodule

bind thermal_poll_ctrl thermal_poll_ctrl_chk #(.QUAL_N(QUAL_N), .QW(QW)) chk_i (
  .clk(clk), .rst_n(rst_n), .adc_start(adc_start), .adc_done(adc_done),
  .busy(busy), .pend_a(pend_a), .shut_out(shut_out), .alarm_cnt(alarm_cnt)
);

// File: tb/thermal_poll_ctrl_tb_top.sv
`timescale 1ns/1ps
module thermal_poll_ctrl_tb_top;
  localparam int SLOW = 1000;
  localparam int FAST = 100;
  localparam int QN   = 10;
  localparam int NV   = 15;

  localparam logic [11:0] V_CODE [NV] = '{12'h800, 12'h700, 12'h650, 12'h701,
    12'h600, 12'h600, 12'h600, 12'h600, 12'h600, 12'h600, 12'h600, 12'h600,
    12'h600, 12'h600, 12'h900};
  localparam int V_GAP [NV] = '{SLOW, SLOW, FAST, FAST, SLOW, FAST, FAST, FAST,
    FAST, FAST, FAST, FAST, FAST, FAST, FAST};
  localparam bit V_IRQ [NV] = '{0,0,0,0,0,0,0,0,0,0,0,0,0,1,1};

  logic clk = 0, rst_n = 0, bus_we = 0, adc_done = 0;
  logic [2:0] bus_addr = 0;
  logic [31:0] bus_wdata = 0, bus_rdata;
  logic [11:0] adc_code = 0;
  logic adc_start, irq, shut_out;
  int tests = 0, fails = 0;

  always #2.5 clk = ~clk;

  thermal_poll_ctrl #(.CODE_W(12), .SLOW_TICKS(SLOW), .FAST_TICKS(FAST), .QUAL_N(QN)) dut_i (
    .clk(clk), .rst_n(rst_n), .bus_we(bus_we), .bus_addr(bus_addr), .bus_wdata(bus_wdata),
    .bus_rdata(bus_rdata), .adc_start(adc_start), .adc_done(adc_done), .adc_code(adc_code),
    .irq(irq), .shut_out(shut_out));

  task automatic chk(input string req, input int act, input int exp);
    tests++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic wr(input logic [2:0] a, input logic [31:0] d);
    @(negedge clk); bus_addr = a; bus_wdata = d; bus_we = 1;
    @(posedge clk); @(negedge clk); bus_we = 0; bus_addr = 0;
  endtask

  task automatic rd(input logic [2:0] a, output logic [31:0] d);
    bus_addr = a; #0.1; d = bus_rdata; bus_addr = 0; #0.1;
  endtask

  task automatic conv(input logic [11:0] code, input int exp_gap, input string req);
    int n = 0;
    bit seen = 0;
    logic [31:0] r;
    while (!seen && n < 3000) begin
      @(posedge clk); n++;
      @(negedge clk); if (adc_start) seen = 1;
    end
    chk({req, " start seen"}, seen, 1);
    if (exp_gap > 0) chk({req, " gap"}, n, exp_gap);
    rd(3'd0, r);
    chk("R9 busy during conversion", r[16], 1);
    @(negedge clk); @(negedge clk);
    adc_done = 1; adc_code = code;
    @(posedge clk); @(negedge clk);
    adc_done = 0;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    fails++;
    $display("FAIL watchdog: actual %0d expected %0d", 1, 0);
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    logic [31:0] r;
    repeat (3) @(posedge clk);
    @(negedge clk); rst_n = 1;
    // R12 reset state
    chk("R12 adc_start", adc_start, 0);
    chk("R12 irq", irq, 0);
    chk("R12 shut_out", shut_out, 0);
    rd(3'd0, r); chk("R12 control", r, 0);
    rd(3'd2, r); chk("R12 pending", r, 0);
    rd(3'd3, r); chk("R12 latest code", r, 0);

    wr(3'd4, 32'h700);
    wr(3'd5, 32'h300);
    wr(3'd1, 32'h22);
    wr(3'd0, 32'h21);

    // Vector walk: R1 R2 R3 R4 R10
    for (int i = 0; i < NV; i++) begin
      conv(V_CODE[i], V_GAP[i], (V_GAP[i] == SLOW) ? "R1 slow" : "R2 fast");
      rd(3'd0, r); chk("R9 idle after done", r[16], 0);
      rd(3'd3, r); chk("R10 latest code", r, int'(V_CODE[i]));
      chk("R3 irq after run", irq, int'(V_IRQ[i]));
      chk("R6 no shutdown", shut_out, 0);
    end

    // R4 masking keeps pending
    wr(3'd1, 32'h20);
    chk("R4 irq masked", irq, 0);
    rd(3'd2, r); chk("R4 pending kept", r[1], 1);
    wr(3'd1, 32'h22);
    chk("R4 irq unmasked", irq, 1);
    // R5 clear
    wr(3'd2, 32'h2);
    chk("R5 irq cleared", irq, 0);
    rd(3'd2, r); chk("R5 pending cleared", r[1], 0);

    // R6 R7 R11 shutdown run with mid-run limit rewrite
    for (int k = 1; k <= QN; k++) begin
      conv(12'h100, 0, "R6 hot run");
      if (k == 5) wr(3'd5, 32'h200);
      chk("R6 R11 shut_out timing", shut_out, (k == QN) ? 1 : 0);
    end
    rd(3'd2, r); chk("R6 shutdown pending", r[5], 1);
    conv(12'hA00, FAST, "R2 fast after hot");
    chk("R7 shut_out latched", shut_out, 1);
    conv(12'hA00, SLOW, "R2 back to slow");

    // R8 enables
    wr(3'd0, 32'h20);
    begin
      int starts = 0;
      for (int c = 0; c < SLOW + 50; c++) begin @(negedge clk); if (adc_start) starts++; end
      chk("R8 auto enable cleared", starts, 0);
    end
    wr(3'd0, 32'h01);
    begin
      int starts = 0;
      for (int c = 0; c < SLOW + 50; c++) begin @(negedge clk); if (adc_start) starts++; end
      chk("R8 source enable cleared", starts, 0);
    end
    wr(3'd0, 32'h21);
    conv(12'hA00, SLOW, "R8 R1 re-enabled");
    chk("R7 shut_out still latched", shut_out, 1);

    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule